// File: doc/BRIEF.md
# Prioritised Interrupt Controller for an 8-bit Core

This block decides, at each instruction boundary of a small 8-bit processor, whether an interrupt is taken and which one. It watches five request lines: a non-maskable line, three numbered restart lines (7.5, 6.5 and 5.5) and a general external request. The non-maskable line and the 7.5 line are captured on their rising edges. The 6.5, 5.5 and external lines are used as levels. The block keeps a small control/status byte that the core writes to change masks and reads back to see pending requests and the enable state.

The core tells the block about enable and disable commands, whether it is halted, and when an instruction boundary happens. One clock after a boundary where a request wins, the block gives a one-cycle grant pulse. With the pulse come the fixed 16-bit vector, an acknowledge status code, and a wake flag that tells the core to leave HALT and step its saved program counter past the halt. When the non-maskable request is taken, the block also keeps a snapshot of the status byte.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the grant outputs are zero, global enable is 0 and all three masks are 1, so `status_o` reads 0x07 when all lines are low.
- R2: A rising edge on `nmi_i` latches a request. It is granted with vector 0x0024 whatever the enable and mask state. Holding the line high gives only one grant.
- R3: A rising edge on `ir75_i` sets status bit 6, which stays set after the line falls. Granting it gives vector 0x003C and clears bit 6.
- R4: Status bits 5 and 4 follow the `ir65_i` and `ir55_i` levels, and bit 7 follows `sin_i`. The vectors are 0x0034 (6.5), 0x002C (5.5) and 0x0038 (external).
- R5: Priority from highest to lowest is non-maskable, 7.5, 6.5, 5.5, external.
- R6: A maskable source is granted only when enable (status bit 3) is 1 and its mask bit is 0. The mask bits are bit 2 for 7.5, bit 1 for 6.5 and bit 0 for 5.5. The external source needs only the enable.
- R7: A config write with `cfg_wdata_i[3]`=1 loads masks from bits 2..0. With bit 3 at 0 the masks are left unchanged. Bit 4 set clears the 7.5 pending bit, whatever its mask.
- R8: After an enable command, the first boundary grants no maskable source and the second one may. The non-maskable source is granted during this delay.
- R9: Granting a maskable source clears the enable. A disable command clears it too and blocks maskable grants.
- R10: `take_o` pulses exactly one cycle after a boundary with a winner, and at no other time. `vec_o`, `ack_o` and `resume_o` are zero when `take_o` is 0.
- R11: The acknowledge code is 0x23 when not halted. When `halted_i` is set at the boundary it is 0x26, and `resume_o` is 1.
- R12: `trap_copy_o` takes the value `status_o` had in the boundary cycle in which the non-maskable request was granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_i | input | 1 | Non-maskable request, edge captured |
| ir75_i | input | 1 | Restart 7.5 request, edge captured |
| ir65_i | input | 1 | Restart 6.5 request, level |
| ir55_i | input | 1 | Restart 5.5 request, level |
| ext_i | input | 1 | General external request, level |
| sin_i | input | 1 | Serial input level shown in status bit 7 |
| cfg_wr_i | input | 1 | Config write strobe |
| cfg_wdata_i | input | 5 | Config data: [4] clear 7.5 pending, [3] load masks, [2:0] masks |
| ei_i | input | 1 | Enable-interrupts command |
| di_i | input | 1 | Disable-interrupts command |
| halted_i | input | 1 | Core is halted |
| boundary_i | input | 1 | Instruction boundary strobe |
| status_o | output | 8 | Status byte {sin, p7.5, p6.5, p5.5, enable, m7.5, m6.5, m5.5} |
| take_o | output | 1 | Grant pulse |
| vec_o | output | 16 | Grant vector address |
| ack_o | output | 8 | Acknowledge status code |
| resume_o | output | 1 | Leave HALT and advance the saved PC |
| trap_copy_o | output | 8 | Status snapshot at the last non-maskable grant |

## Verification
Each grant shows up one clock after the boundary strobe that caused it. The bench drives every input at a falling edge and checks the grant at the next falling edge. Register-held status bits (masks, enable, 7.5 pending) change one clock after the write, edge or command. The level bits and `sin_i` show up in the same cycle. Status reads are therefore made one falling edge after the stimulus. A scoreboard queues one expected result for each boundary strobe, and a monitor pops it exactly one cycle later. Any grant with no strobe before it is reported under R10.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int STAT_W     = 8;
    localparam int VEC_W      = 16;
    localparam int ACK_W      = 8;
    localparam int MSK_W      = 3;
    localparam int CFG_W      = 5;
    localparam int EI_DELAY   = 2;
    localparam int EDGE_N     = 2;
    localparam int CFG_CLR75  = 4;
    localparam int CFG_LOADMK = 3;

    localparam logic [VEC_W-1:0] VEC_NMI = 16'h0024;
    localparam logic [VEC_W-1:0] VEC_I75 = 16'h003C;
    localparam logic [VEC_W-1:0] VEC_I65 = 16'h0034;
    localparam logic [VEC_W-1:0] VEC_I55 = 16'h002C;
    localparam logic [VEC_W-1:0] VEC_EXT = 16'h0038;

    localparam logic [ACK_W-1:0] ACK_RUN  = 8'h23;
    localparam logic [ACK_W-1:0] ACK_WAKE = 8'h26;

    typedef enum logic [2:0] {
        SRC_NONE, SRC_NMI, SRC_I75, SRC_I65, SRC_I55, SRC_EXT
    } src_e;

    // bit order is visible to software, so it is fixed
    typedef struct packed {
        logic             sin;
        logic             p75;
        logic             p65;
        logic             p55;
        logic             ie;
        logic [MSK_W-1:0] msk;   // [2]=7.5 [1]=6.5 [0]=5.5
    } stat_t;

    typedef struct packed {
        logic             take;
        logic [VEC_W-1:0] vec;
        logic [ACK_W-1:0] ack;
        logic             wake;
    } grant_t;

    function automatic logic [VEC_W-1:0] vec_of(src_e s);
        case (s)
            SRC_NMI: return VEC_NMI;
            SRC_I75: return VEC_I75;
            SRC_I65: return VEC_I65;
            SRC_I55: return VEC_I55;
            SRC_EXT: return VEC_EXT;
            default: return '0;
        endcase
    endfunction

    function automatic src_e pick(logic nmi_p, logic p75, logic l65,
                                  logic l55, logic ext, logic gate,
                                  logic [MSK_W-1:0] msk);
        if (nmi_p)                    return SRC_NMI;
        else if (gate && p75 && !msk[2]) return SRC_I75;
        else if (gate && l65 && !msk[1]) return SRC_I65;
        else if (gate && l55 && !msk[0]) return SRC_I55;
        else if (gate && ext)            return SRC_EXT;
        else                             return SRC_NONE;
    endfunction

    function automatic grant_t make_grant(src_e s, logic halted);
        grant_t g;
        g = '0;
        if (s != SRC_NONE) begin
            g.take = 1'b1;
            g.vec  = vec_of(s);
            g.ack  = halted ? ACK_WAKE : ACK_RUN;
            g.wake = halted;
        end
        return g;
    endfunction

endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    input  logic clr_i,
    output logic pend_o
);
    logic prev_q;
    logic pend_q;
    logic rise;

    assign rise = line_i && !prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= line_i;
            pend_q <= 1'b0;
        end else begin
            prev_q <= line_i;
            if (rise)
                pend_q <= 1'b1;
            else if (clr_i)
                pend_q <= 1'b0;
        end
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/irq_enable_window.sv
module irq_enable_window #(
    parameter int DELAY = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ei_i,
    input  logic di_i,
    input  logic bnd_i,
    output logic open_o
);
    localparam int W = $clog2(DELAY + 1);
    localparam logic [W-1:0] LOAD = W'(DELAY);
    localparam logic [W-1:0] ONE  = W'(1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || di_i)
            cnt_q <= '0;
        else if (ei_i)
            cnt_q <= LOAD;
        else if (bnd_i && cnt_q != '0)
            cnt_q <= cnt_q - ONE;
    end

    // a boundary that brings the count to zero already admits requests
    assign open_o = (cnt_q <= ONE);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_prio_pkg::*;
(
    input  logic             nmi_p_i,
    input  logic             p75_i,
    input  logic             l65_i,
    input  logic             l55_i,
    input  logic             ext_i,
    input  logic             ie_i,
    input  logic             open_i,
    input  logic             ei_now_i,
    input  logic [MSK_W-1:0] msk_i,
    output src_e             sel_o
);
    logic gate;

    assign gate  = ie_i && open_i && !ei_now_i;
    assign sel_o = pick(nmi_p_i, p75_i, l65_i, l55_i, ext_i, gate, msk_i);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                nmi_i,
    input  logic                ir75_i,
    input  logic                ir65_i,
    input  logic                ir55_i,
    input  logic                ext_i,
    input  logic                sin_i,
    input  logic                cfg_wr_i,
    input  logic [CFG_W-1:0]    cfg_wdata_i,
    input  logic                ei_i,
    input  logic                di_i,
    input  logic                halted_i,
    input  logic                boundary_i,
    output logic [STAT_W-1:0]   status_o,
    output logic                take_o,
    output logic [VEC_W-1:0]    vec_o,
    output logic [ACK_W-1:0]    ack_o,
    output logic                resume_o,
    output logic [STAT_W-1:0]   trap_copy_o
);
    localparam int E_NMI = 0;
    localparam int E_I75 = 1;

    logic [EDGE_N-1:0] edge_line;
    logic [EDGE_N-1:0] edge_clr;
    logic [EDGE_N-1:0] edge_pend;

    logic              ie_q;
    logic [MSK_W-1:0]  msk_q;
    logic [STAT_W-1:0] snap_q;
    grant_t            gnt_q;
    logic              win_open;
    src_e              sel;
    stat_t             stat;
    logic              take_nmi;
    logic              take_mask;

    assign take_nmi  = boundary_i && (sel == SRC_NMI);
    assign take_mask = boundary_i && (sel != SRC_NONE) && (sel != SRC_NMI);

    assign edge_line[E_NMI] = nmi_i;
    assign edge_line[E_I75] = ir75_i;
    assign edge_clr[E_NMI]  = take_nmi;
    assign edge_clr[E_I75]  = (boundary_i && sel == SRC_I75)
                           || (cfg_wr_i && cfg_wdata_i[CFG_CLR75]);

    generate
        for (genvar g = 0; g < EDGE_N; g++) begin : g_edge
            irq_edge_latch u_lat (
                .clk    (clk),
                .rst    (rst),
                .line_i (edge_line[g]),
                .clr_i  (edge_clr[g]),
                .pend_o (edge_pend[g])
            );
        end
    endgenerate

    irq_enable_window #(.DELAY(EI_DELAY)) u_win (
        .clk    (clk),
        .rst    (rst),
        .ei_i   (ei_i),
        .di_i   (di_i),
        .bnd_i  (boundary_i),
        .open_o (win_open)
    );

    irq_prio_pick u_pick (
        .nmi_p_i  (edge_pend[E_NMI]),
        .p75_i    (edge_pend[E_I75]),
        .l65_i    (ir65_i),
        .l55_i    (ir55_i),
        .ext_i    (ext_i),
        .ie_i     (ie_q),
        .open_i   (win_open),
        .ei_now_i (ei_i),
        .msk_i    (msk_q),
        .sel_o    (sel)
    );

    always_comb begin
        stat.sin = sin_i;
        stat.p75 = edge_pend[E_I75];
        stat.p65 = ir65_i;
        stat.p55 = ir55_i;
        stat.ie  = ie_q;
        stat.msk = msk_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q   <= 1'b0;
            msk_q  <= '1;
            snap_q <= '0;
            gnt_q  <= '0;
        end else begin
            if (cfg_wr_i && cfg_wdata_i[CFG_LOADMK])
                msk_q <= cfg_wdata_i[MSK_W-1:0];
            if (di_i || take_mask)
                ie_q <= 1'b0;
            else if (ei_i)
                ie_q <= 1'b1;
            if (take_nmi)
                snap_q <= stat;
            gnt_q <= boundary_i ? make_grant(sel, halted_i) : '0;
        end
    end

    assign status_o    = stat;
    assign take_o      = gnt_q.take;
    assign vec_o       = gnt_q.vec;
    assign ack_o       = gnt_q.ack;
    assign resume_o    = gnt_q.wake;
    assign trap_copy_o = snap_q;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
    import irq_prio_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                ir75_i,
    input logic                cfg_wr_i,
    input logic [CFG_W-1:0]    cfg_wdata_i,
    input logic                halted_i,
    input logic                boundary_i,
    input logic [STAT_W-1:0]   status_o,
    input logic                take_o,
    input logic [VEC_W-1:0]    vec_o,
    input logic [ACK_W-1:0]    ack_o,
    input logic                resume_o,
    input logic [STAT_W-1:0]   trap_copy_o
);
    AST_TAKE_AFTER_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        take_o |-> $past(boundary_i)); // R10

    AST_IDLE_OUTPUTS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !take_o |-> (vec_o == '0 && ack_o == '0 && !resume_o)); // R10

    AST_VECTOR_LEGAL: assert property (@(posedge clk) disable iff (rst)
        take_o |-> (vec_o == VEC_NMI || vec_o == VEC_I75 || vec_o == VEC_I65
                    || vec_o == VEC_I55 || vec_o == VEC_EXT)); // R4

    AST_WAKE_CODE: assert property (@(posedge clk) disable iff (rst)
        take_o |-> (resume_o == $past(halted_i))
                   && (ack_o == (resume_o ? ACK_WAKE : ACK_RUN))); // R11

    AST_MASKABLE_DROPS_IE: assert property (@(posedge clk) disable iff (rst)
        (take_o && vec_o != VEC_NMI) |-> !status_o[3]); // R9

    AST_SNAPSHOT_ON_NMI: assert property (@(posedge clk) disable iff (rst)
        (take_o && vec_o == VEC_NMI) |-> trap_copy_o == $past(status_o)); // R12

    AST_CFG_CLEARS_P75: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr_i && cfg_wdata_i[CFG_CLR75] && !ir75_i) |=> !status_o[6]); // R7
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ir75_i      (ir75_i),
    .cfg_wr_i    (cfg_wr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .halted_i    (halted_i),
    .boundary_i  (boundary_i),
    .status_o    (status_o),
    .take_o      (take_o),
    .vec_o       (vec_o),
    .ack_o       (ack_o),
    .resume_o    (resume_o),
    .trap_copy_o (trap_copy_o)
);

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
    import irq_prio_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nmi = 0, ir75 = 0, ir65 = 0, ir55 = 0, ext = 0, sin = 0;
    logic        cfg_wr = 0;
    logic [4:0]  cfg_wdata = '0;
    logic        ei = 0, di = 0, halted = 0, boundary = 0;
    logic [7:0]  status_o, ack_o, trap_copy_o;
    logic        take_o, resume_o;
    logic [15:0] vec_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prio_ctrl uut (
        .clk(clk), .rst(rst), .nmi_i(nmi), .ir75_i(ir75), .ir65_i(ir65),
        .ir55_i(ir55), .ext_i(ext), .sin_i(sin), .cfg_wr_i(cfg_wr),
        .cfg_wdata_i(cfg_wdata), .ei_i(ei), .di_i(di), .halted_i(halted),
        .boundary_i(boundary), .status_o(status_o), .take_o(take_o),
        .vec_o(vec_o), .ack_o(ack_o), .resume_o(resume_o),
        .trap_copy_o(trap_copy_o)
    );

    typedef struct packed {
        logic        take;
        logic [15:0] vec;
        logic [7:0]  ack;
        logic        res;
    } exp_t;

    int     checks = 0;
    int     errors = 0;
    exp_t   expq[$];
    string  tagq[$];
    logic   bnd_d = 1'b0;

    always @(posedge clk) bnd_d <= boundary;

    // monitor: a result is due one clock after each boundary strobe (R10)
    always @(negedge clk) begin
        if (!rst) begin
            if (bnd_d) begin
                exp_t  e;
                string t;
                checks++;
                if (expq.size() == 0) begin
                    errors++;
                    $display("FAIL R10: result with empty scoreboard, take=%0b expected none", take_o);
                end else begin
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    if ({take_o, vec_o, ack_o, resume_o} !== e) begin
                        errors++;
                        $display("FAIL %s: take=%0b vec=%h ack=%h res=%0b expected take=%0b vec=%h ack=%h res=%0b",
                                 t, take_o, vec_o, ack_o, resume_o, e.take, e.vec, e.ack, e.res);
                    end
                end
            end else if (take_o !== 1'b0) begin
                checks++;
                errors++;
                $display("FAIL R10: take=%0b without boundary, expected 0", take_o);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic strobe(input logic t, input logic [15:0] v, input logic h, input string tag);
        exp_t e;
        e.take = t;
        e.vec  = t ? v : 16'h0000;
        e.ack  = t ? (h ? 8'h26 : 8'h23) : 8'h00;
        e.res  = t & h;
        expq.push_back(e);
        tagq.push_back(tag);
        boundary = 1'b1;
        halted   = h;
        tick();
        boundary = 1'b0;
        halted   = 1'b0;
    endtask

    task automatic chk8(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [4:0] d);
        cfg_wr = 1'b1; cfg_wdata = d; tick(); cfg_wr = 1'b0; cfg_wdata = '0;
    endtask

    task automatic do_ei();
        ei = 1'b1; tick(); ei = 1'b0;
    endtask

    task automatic do_di();
        di = 1'b1; tick(); di = 1'b0;
    endtask

    task automatic pulse75();
        ir75 = 1'b1; tick(); ir75 = 1'b0;
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk8(status_o, 8'h07, "R1 status after reset");
        chk8({7'd0, take_o}, 8'h00, "R1 take after reset");

        // R2 edge-captured non-maskable, ignores enable/masks
        nmi = 1'b1; tick();
        strobe(1, VEC_NMI, 0, "R2 nmi grant");
        chk8(trap_copy_o, 8'h07, "R12 snapshot");
        strobe(0, 0, 0, "R2 held high no regrant");
        nmi = 1'b0; tick();

        // R7 mask load, R3 sticky 7.5, R6 enable needed, R8 delay
        cfg(5'h08);
        chk8(status_o, 8'h00, "R7 masks loaded");
        pulse75();
        chk8(status_o, 8'h40, "R3 pending sticky");
        strobe(0, 0, 0, "R6 enable off blocks");
        do_ei();
        chk8(status_o, 8'h48, "R9 enable set");
        strobe(0, 0, 0, "R8 first boundary blocked");
        strobe(1, VEC_I75, 0, "R3 7.5 grant");
        chk8(status_o, 8'h00, "R3 R9 pending and enable cleared");

        // R4 levels, R5 priority among levels, R6 masks
        do_ei();
        strobe(0, 0, 0, "R8 delay");
        ir65 = 1'b1; ir55 = 1'b1; ext = 1'b1;
        tick();
        chk8(status_o, 8'h38, "R4 level bits");
        strobe(1, VEC_I65, 0, "R5 6.5 over 5.5 and ext");
        strobe(0, 0, 0, "R6 ext blocked with enable off");
        cfg(5'h0A);
        chk8(status_o, 8'h32, "R7 mask 6.5");
        do_ei();
        strobe(0, 0, 0, "R8 delay");
        strobe(1, VEC_I55, 0, "R6 masked 6.5 skipped");
        cfg(5'h0B);
        do_ei();
        strobe(0, 0, 0, "R8 delay");
        strobe(1, VEC_EXT, 0, "R6 ext needs only enable");
        ir65 = 1'b0; ir55 = 1'b0; ext = 1'b0;

        // R5 7.5 above 6.5
        cfg(5'h08);
        ir65 = 1'b1;
        pulse75();
        do_ei();
        strobe(0, 0, 0, "R8 delay");
        strobe(1, VEC_I75, 0, "R5 7.5 over 6.5");

        // R8 non-maskable during delay, R12 snapshot
        do_ei();
        nmi = 1'b1; tick();
        strobe(1, VEC_NMI, 0, "R8 nmi during delay");
        chk8(trap_copy_o, 8'h28, "R12 snapshot with enable");
        strobe(1, VEC_I65, 0, "R8 window opens");
        nmi = 1'b0; ir65 = 1'b0; tick();

        // R7 clear pending regardless of mask, masks kept
        cfg(5'h0C);
        pulse75();
        chk8(status_o, 8'h44, "R3 pending while masked");
        cfg(5'h10);
        chk8(status_o, 8'h04, "R7 clear 7.5 masks kept");

        // R11 halted acknowledge, R9 disable
        cfg(5'h08);
        do_ei();
        strobe(0, 0, 0, "R8 delay");
        ext = 1'b1;
        strobe(1, VEC_EXT, 1, "R11 wake from halt");
        do_ei();
        strobe(0, 0, 0, "R8 delay");
        do_di();
        chk8(status_o, 8'h00, "R9 disable clears enable");
        strobe(0, 0, 0, "R9 disable blocks ext");
        ext = 1'b0;
        nmi = 1'b1; tick();
        strobe(1, VEC_NMI, 1, "R11 nmi while halted");
        nmi = 1'b0;

        // R4 serial input bit
        sin = 1'b1; tick();
        chk8(status_o, 8'h80, "R4 serial bit");

        repeat (3) tick();
        chk8(8'(expq.size()), 8'h00, "R10 scoreboard drained");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL R10: watchdog expired, got hang expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule